// File: doc/BRIEF.md
# Per-Slot Signaling Capture

This block sits on the transmit side of a time-division system bus. Beside the PCM data stream runs a serial signaling stream with the same slot layout. Each 8-bit slot of that stream carries the four signaling bits A, B, C and D for the PCM slot that shares its position. An external timebase tells the block which slot and which bit is on the wire, and strobes a sampling enable once per bus bit. It also flags the first bit of each multiframe.

The block captures signaling only during the first frame of each multiframe. The capture window opens on the sampled bit that carries the multiframe-start flag. It closes after bit 7 of the last slot of that frame. For each slot, the block collects the bits at positions 4 to 7. It commits all four bits to that slot's 4-bit entry at once, so a reader never sees a half-updated nibble. A one-cycle strobe follows the write of the last slot.

The entry count depends on the line mode: 24 in T1 mode and 32 in E1 mode. A combinational read port, indexed by slot, returns the stored nibble.

Top module: `sigcap_top`

## Requirements
- R1: While rst_ni is low and after its release, every entry reads 4'b0000 and upd_o is low.
- R2: The capture window opens on the enabled bit where mf_start_i is high. It closes after the enabled bit with bit_pos_i = 7 on the last slot: 23 in T1, 31 in E1. Signaling bits are taken only inside this window.
- R3: Within a slot, the bits sampled at positions 4, 5, 6 and 7 are stored as A, B, C and D. They read back as rd_abcd_o[3] = A, [2] = B, [1] = C, [0] = D.
- R4: A slot's entry is written only on the enabled bit at position 7. The new nibble appears on the read port in the next cycle, so no partial nibble is ever visible.
- R5: The register file has 24 entries when e1_mode_i = 0 and 32 when e1_mode_i = 1. Reads of a slot index at or above the active count return 4'b0000, and writes to such indices are dropped.
- R6: Outside the capture window, every entry keeps its value whatever the signaling input does.
- R7: upd_o is high for exactly one cycle, in the cycle after the last slot of a capture frame is written.
- R8: Cycles with bit_en_i low sample nothing. bit_pos_i, slot_idx_i, sig_i and mf_start_i are ignored in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sig_i | input | 1 | Serial signaling bit |
| bit_en_i | input | 1 | Sample enable, one per bus bit |
| bit_pos_i | input | 3 | Bit position in the slot, 0 first |
| slot_idx_i | input | 5 | Slot index in the frame |
| mf_start_i | input | 1 | First bit of a multiframe |
| e1_mode_i | input | 1 | 0: T1 (24 slots), 1: E1 (32 slots) |
| rd_slot_i | input | 5 | Read index |
| rd_abcd_o | output | 4 | Stored {A,B,C,D} for rd_slot_i |
| upd_o | output | 1 | One-cycle pulse after a capture frame completes |

## Verification
The bench builds the block with its defaults: 32 maximum slots, 24 T1 slots, 8-bit slots and 4 signaling bits. These values let it reach the T1 last-slot boundary at 23 and the E1 boundary at 31. They also exercise the out-of-range reads of slots 24 to 31 in T1 mode, including after E1 frames have filled them. Enable gaps carrying random garbage, non-capture frames with fresh data, and mode switches between multiframes all fall within these widths.

// File: rtl/sigcap_pkg.sv
package sigcap_pkg;
  localparam int ABCD_W = 4;
  typedef logic [ABCD_W-1:0] abcd_t;
endpackage

// File: rtl/sigcap_frame_ctl.sv
module sigcap_frame_ctl #(
  parameter int MAX_SLOTS     = 32,
  parameter int T1_SLOTS      = 24,
  parameter int BITS_PER_SLOT = 8,
  localparam int SLOT_IW = $clog2(MAX_SLOTS),
  localparam int POS_W   = $clog2(BITS_PER_SLOT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               mf_start_i,
  input  logic [POS_W-1:0]   bit_pos_i,
  input  logic [SLOT_IW-1:0] slot_idx_i,
  input  logic               e1_mode_i,
  output logic               win_o,
  output logic               upd_o
);
  logic win_q, upd_q, last_hit;
  logic [SLOT_IW-1:0] last_slot;

  assign last_slot = e1_mode_i ? SLOT_IW'(MAX_SLOTS-1) : SLOT_IW'(T1_SLOTS-1);
  assign last_hit  = bit_en_i && (bit_pos_i == POS_W'(BITS_PER_SLOT-1)) &&
                     (slot_idx_i == last_slot);
  assign win_o     = win_q || (bit_en_i && mf_start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= win_o && last_hit;
      if (bit_en_i) begin
        if (win_o && last_hit) win_q <= 1'b0;
        else if (mf_start_i)   win_q <= 1'b1;
      end
    end
  end

  assign upd_o = upd_q;

  assert_upd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);
  assert_win_closed_after_upd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_o) |-> !win_q);
endmodule

// File: rtl/sigcap_assembler.sv
module sigcap_assembler #(
  parameter int BITS_PER_SLOT = 8,
  parameter int SIG_BITS      = 4,
  localparam int POS_W     = $clog2(BITS_PER_SLOT),
  localparam int SH_W      = SIG_BITS - 1,
  localparam int FIRST_POS = BITS_PER_SLOT - SIG_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                bit_en_i,
  input  logic                sig_i,
  input  logic [POS_W-1:0]    bit_pos_i,
  output logic [SIG_BITS-1:0] word_o,
  output logic                done_o
);
  logic [SH_W-1:0]     sh_q;
  logic [SIG_BITS-1:0] cat;
  logic                take, last;

  assign cat  = {sh_q, sig_i};
  assign last = bit_pos_i == POS_W'(BITS_PER_SLOT-1);
  assign take = cap_i && bit_en_i && (bit_pos_i >= POS_W'(FIRST_POS)) && !last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (take) sh_q <= cat[SH_W-1:0];
  end

  assign word_o = cat;
  assign done_o = cap_i && bit_en_i && last;
endmodule

// File: rtl/sigcap_regfile.sv
module sigcap_regfile #(
  parameter int N  = 32,
  parameter int W  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && waddr_i == IW'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sigcap_top.sv
module sigcap_top
  import sigcap_pkg::*;
#(
  parameter int MAX_SLOTS     = 32,
  parameter int T1_SLOTS      = 24,
  parameter int BITS_PER_SLOT = 8,
  parameter int SIG_BITS      = ABCD_W,
  localparam int SLOT_IW = $clog2(MAX_SLOTS),
  localparam int POS_W   = $clog2(BITS_PER_SLOT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sig_i,
  input  logic               bit_en_i,
  input  logic [POS_W-1:0]   bit_pos_i,
  input  logic [SLOT_IW-1:0] slot_idx_i,
  input  logic               mf_start_i,
  input  logic               e1_mode_i,
  input  logic [SLOT_IW-1:0] rd_slot_i,
  output logic [SIG_BITS-1:0] rd_abcd_o,
  output logic               upd_o
);
  logic               win, done, we_w;
  logic [SLOT_IW:0]   n_slots;
  logic [SIG_BITS-1:0] word, rdata;

  assign n_slots = e1_mode_i ? (SLOT_IW+1)'(MAX_SLOTS) : (SLOT_IW+1)'(T1_SLOTS);

  sigcap_frame_ctl #(
    .MAX_SLOTS(MAX_SLOTS), .T1_SLOTS(T1_SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT)
  ) u_ctl (
    .clk_i, .rst_ni, .bit_en_i, .mf_start_i, .bit_pos_i, .slot_idx_i, .e1_mode_i,
    .win_o(win), .upd_o
  );

  sigcap_assembler #(.BITS_PER_SLOT(BITS_PER_SLOT), .SIG_BITS(SIG_BITS)) u_asm (
    .clk_i, .rst_ni, .cap_i(win), .bit_en_i, .sig_i, .bit_pos_i,
    .word_o(word), .done_o(done)
  );

  // drop writes past the active slot count
  assign we_w = done && ({1'b0, slot_idx_i} < n_slots);

  sigcap_regfile #(.N(MAX_SLOTS), .W(SIG_BITS)) u_rf (
    .clk_i, .rst_ni, .we_i(we_w), .waddr_i(slot_idx_i), .wdata_i(word),
    .raddr_i(rd_slot_i), .rdata_o(rdata)
  );

  assign rd_abcd_o = ({1'b0, rd_slot_i} < n_slots) ? rdata : '0;

  assert_wr_at_last_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_w |-> (bit_en_i && bit_pos_i == POS_W'(BITS_PER_SLOT-1)));
  assert_wr_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_w |-> win);
  assert_rd_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, rd_slot_i} >= n_slots) |-> (rd_abcd_o == '0));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!we_w) && $stable(rd_slot_i) && $stable(e1_mode_i)) |-> $stable(rd_abcd_o));
endmodule

// File: tb/sigcap_top_tb.sv
module sigcap_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sig = 0, bit_en = 0, mf = 0, e1 = 0;
  logic [2:0] bpos = 0;
  logic [4:0] slot = 0, rd_slot = 0;
  logic [3:0] rd_abcd;
  logic upd;
  int vecs = 0, errs = 0;
  string tag = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  sigcap_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .bit_en_i(bit_en), .bit_pos_i(bpos),
    .slot_idx_i(slot), .mf_start_i(mf), .e1_mode_i(e1), .rd_slot_i(rd_slot),
    .rd_abcd_o(rd_abcd), .upd_o(upd)
  );

  // behavioural reference
  logic [3:0] exp_mem [32];
  bit exp_win, exp_upd;
  int sh;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (exp_mem[i]) exp_mem[i] = 4'h0;
      exp_win = 0; exp_upd = 0; sh = 0;
    end else begin
      int n;
      bit act;
      n = e1 ? 32 : 24;
      act = exp_win || (bit_en && mf);
      exp_upd = 0;
      if (bit_en) begin
        if (act && bpos >= 4 && bpos <= 6) sh = ((sh << 1) | int'(sig)) & 7;
        if (act && bpos == 7) begin
          if (slot < n) exp_mem[slot] = 4'(((sh << 1) | int'(sig)) & 15);
          if (slot == n - 1) begin exp_win = 0; exp_upd = 1; end
          else if (mf) exp_win = 1;
        end else if (mf) exp_win = 1;
      end
    end
  end

  always @(negedge clk) if (!finished) begin
    logic [3:0] e;
    e = (rd_slot < (e1 ? 32 : 24)) ? exp_mem[rd_slot] : 4'h0;
    vecs++;
    if (rd_abcd !== e) begin
      errs++;
      $display("FAIL %s (R3/R4/R6 data) slot %0d: got %h exp %h", tag, rd_slot, rd_abcd, e);
    end
    vecs++;
    if (upd !== exp_upd) begin
      errs++;
      $display("FAIL R7 strobe: got %b exp %b", upd, exp_upd);
    end
  end

  task automatic step(input bit en, input bit s, input bit m, input int sl, input int bp);
    @(posedge clk); #2;
    bit_en = en; sig = s; mf = m; slot = 5'(sl); bpos = 3'(bp);
    rd_slot = 5'($urandom_range(0, 31));
  endtask

  // R8: idle cycles carry garbage on every ignored input
  task automatic frame(input bit first, input int gap_pct);
    int n = e1 ? 32 : 24;
    for (int s = 0; s < n; s++)
      for (int b = 0; b < 8; b++) begin
        while ($urandom_range(0, 99) < gap_pct)
          step(0, 1'($urandom), 1'($urandom), $urandom_range(0, 31), $urandom_range(0, 7));
        step(1, 1'($urandom), first && s == 0 && b == 0, s, b);
      end
  endtask

  task automatic mframe(input int gap_pct);
    for (int f = 0; f < 4; f++) frame(f == 0, gap_pct);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    tag = "R1";
    for (int i = 0; i < 6; i++) begin @(posedge clk); #2; rd_slot = 5'(i * 5); end
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 0);
    tag = "R2 R3 R4 R6 T1";
    mframe(0);
    tag = "R8 gaps T1";
    mframe(30);
    step(0, 0, 0, 0, 0);
    tag = "R5 E1";
    e1 = 1;
    mframe(20);
    mframe(0);
    step(0, 0, 0, 0, 0);
    tag = "R5 back to T1";
    e1 = 0;
    for (int i = 24; i < 32; i++) begin @(posedge clk); #2; rd_slot = 5'(i); end
    mframe(10);
    for (int i = 0; i < 20; i++) step(0, 1'($urandom), 0, 0, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end
endmodule